// File: doc/BRIEF.md
# Parallel Port Mode Exit Sequencer

This block is the host-side sequencer that brings a parallel printer link back from any extended mode (nibble, byte, ECP or bounded ECP) to compatibility mode. A controller raises `start_i` for one cycle. With the pulse it presents the link's current phase, the protocol family and an option that makes the peripheral's XFlag line irrelevant. The sequencer drives the host lines through the exit handshake and samples the peripheral's busy, clock and XFlag lines through a synchronizer. It waits with a programmable timeout counted in microseconds. When it finishes it records a terminated phase, clears its connected flag and pulses `done_o`.

The expected XFlag answer is fixed before the handshake begins. The level seen on XFlag when the start is accepted is stored, and the peripheral must later present the opposite level, but only for the family and phase combinations that call for it. A timeout while waiting for the peripheral's first answer does not abort the sequence. The sequencer jumps straight to the final host step. A timeout during the final settle wait is only flagged.

Top module: `ppmode_exit`

## Requirements
- R1: After reset, `drive_o`=0, `select_in_o`=0, `host_busy_o`=1, `strobe_n_o`=1, `data_o`=0, `done_o`=0, `phase_o`=6 (terminated), `connected_o`=0, and both timeout flags are 0.
- R2: A start accepted while idle (`drive_o`=0) with `phase_i`=6 raises `done_o` in the next cycle and starts no handshake: `drive_o` stays 0 and `host_busy_o` stays 1.
- R3: In the cycle after any other start, `drive_o`=1 with `select_in_o`=0, `host_busy_o`=1, `strobe_n_o`=1 and `data_o`=0. `phase_o` takes `phase_i`, `connected_o`=1, and both timeout flags clear.
- R4: `host_busy_o` falls only after the synchronized `ptr_clk_i` has been seen low, and SYNC_STAGES plus one cycles after the input change at the earliest.
- R5: XFlag is in use when the family is nibble (0) or byte (1) and the phase is reverse idle (2) or reverse transfer (3). It is also in use when the family is ECP (2) or bounded ECP (3) and the phase is any other value.
- R6: When XFlag is in use, `host_busy_o` stays high until XFlag differs from the synchronized level that was sampled in the start cycle.
- R7: With `xflag_ignore_i`=1 at start, XFlag has no effect on when `host_busy_o` falls.
- R8: If the first wait expires, `ack_timeout_o` is set and the sequence proceeds to completion without lowering `host_busy_o`.
- R9: After `host_busy_o` falls, the block waits for synchronized `ptr_busy_i` and `ptr_clk_i` both high, then completes.
- R10: If the settle wait expires, `settle_timeout_o` is set and completion still follows in the next cycle.
- R11: On completion, `done_o` is high for one cycle, `host_busy_o`=1, `drive_o`=0, `phase_o`=6 and `connected_o`=0.
- R12: A wait expires after `timeout_us_i`×CLK_PER_US cycles in the wait state. A run whose first wait times out therefore ends with `done_o` on the (4+`timeout_us_i`×CLK_PER_US)-th cycle after the start cycle.
- R13: When the awaited condition and timer expiry occur on the same edge, the condition wins and no timeout flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the exit sequence |
| phase_i | input | 3 | Current link phase (6 = terminated) |
| family_i | input | 2 | Protocol family: 0 nibble, 1 byte, 2 ECP, 3 bounded ECP |
| xflag_ignore_i | input | 1 | Treat XFlag as don't-care |
| timeout_us_i | input | TMO_W | Wait limit in microseconds |
| ptr_busy_i | input | 1 | Peripheral busy line (asynchronous) |
| ptr_clk_i | input | 1 | Peripheral clock line (asynchronous) |
| xflag_i | input | 1 | Peripheral XFlag line (asynchronous) |
| drive_o | output | 1 | Block owns the host lines |
| select_in_o | output | 1 | Host SelectIn level |
| host_busy_o | output | 1 | Host busy / autofeed level |
| strobe_n_o | output | 1 | Host strobe level |
| data_o | output | DATA_W | Host data bus |
| done_o | output | 1 | One-cycle completion pulse |
| phase_o | output | 3 | Recorded link phase |
| connected_o | output | 1 | Link connected flag |
| ack_timeout_o | output | 1 | First wait expired in the last run |
| settle_timeout_o | output | 1 | Settle wait expired in the last run |

## Verification
Two functions can land on the same clock edge. The peripheral's awaited answer can become visible in exactly the cycle in which the wait timer reaches its limit. Also, a new start can arrive in the cycle that carries the previous run's completion pulse. The bench provokes the first case by dropping `ptr_clk_i` at a cycle chosen so that its synchronized copy reaches the sequencer on the expiry edge. It judges the result by `host_busy_o` falling and `ack_timeout_o` staying clear. A behavioural per-cycle model, which counts wait cycles with integers, confirms every output on every clock.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

   // link phase encodings
   localparam logic [2:0] PH_UNKNOWN  = 3'd0;
   localparam logic [2:0] PH_NEGOT    = 3'd1;
   localparam logic [2:0] PH_REV_IDLE = 3'd2;
   localparam logic [2:0] PH_REV_XFER = 3'd3;
   localparam logic [2:0] PH_FWD_IDLE = 3'd4;
   localparam logic [2:0] PH_FWD_XFER = 3'd5;
   localparam logic [2:0] PH_TERM     = 3'd6;

   // protocol families
   localparam logic [1:0] FAM_NIBBLE = 2'd0;
   localparam logic [1:0] FAM_BYTE   = 2'd1;
   localparam logic [1:0] FAM_ECP    = 2'd2;
   localparam logic [1:0] FAM_BECP   = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ASSERT = 3'd1,   // host lines placed, timer armed next
      ST_W_ACK  = 3'd2,   // waiting for peripheral clock low (+xflag)
      ST_DROP   = 3'd3,   // host busy low, settle wait armed next
      ST_W_SET  = 3'd4,   // waiting for busy and clock high
      ST_FINAL  = 3'd5    // host busy high, phase recorded
   } seq_state_e;

endpackage

// File: rtl/ppx_sync.sv
module ppx_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] pipe_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
            end else begin
               pipe_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ppx_timer.sv
module ppx_timer #(
   parameter int CLK_PER_US = 100,
   parameter int TMO_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expired_o
);

   localparam logic [TMO_W-1:0] CNT_MAX = '1;

   logic [TMO_W-1:0] us_q;
   logic             tick;

   generate
      if (CLK_PER_US == 1) begin : g_direct
         assign tick = !clear_i;
      end else begin : g_prescale
         localparam int PRE_W = $clog2(CLK_PER_US);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               pre_q <= '0;
            else if (clear_i)         pre_q <= '0;
            else if (pre_q == PRE_LAST) pre_q <= '0;
            else                      pre_q <= pre_q + 1'b1;
         end
         assign tick = !clear_i && (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        us_q <= '0;
      else if (clear_i)                  us_q <= '0;
      else if (tick && us_q != CNT_MAX)  us_q <= us_q + 1'b1;
   end

   assign expired_o = (us_q >= limit_i);

endmodule

// File: rtl/ppx_xflag_rule.sv
module ppx_xflag_rule
   import ppx_pkg::*;
(
   input  logic [2:0] phase_i,
   input  logic [1:0] family_i,
   input  logic       ignore_i,
   output logic       use_o
);

   logic reverse_ph;
   logic slow_fam;
   logic ecp_fam;

   always_comb begin
      reverse_ph = (phase_i == PH_REV_IDLE) || (phase_i == PH_REV_XFER);
      slow_fam   = (family_i == FAM_NIBBLE) || (family_i == FAM_BYTE);
      ecp_fam    = (family_i == FAM_ECP)    || (family_i == FAM_BECP);
      use_o      = !ignore_i && ((slow_fam && reverse_ph) || (ecp_fam && !reverse_ph));
   end

endmodule

// File: rtl/ppmode_exit.sv
module ppmode_exit
   import ppx_pkg::*;
#(
   parameter int CLK_PER_US  = 100,
   parameter int TMO_W       = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        phase_i,
   input  logic [1:0]        family_i,
   input  logic              xflag_ignore_i,
   input  logic [TMO_W-1:0]  timeout_us_i,
   input  logic              ptr_busy_i,
   input  logic              ptr_clk_i,
   input  logic              xflag_i,
   output logic              drive_o,
   output logic              select_in_o,
   output logic              host_busy_o,
   output logic              strobe_n_o,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o,
   output logic [2:0]        phase_o,
   output logic              connected_o,
   output logic              ack_timeout_o,
   output logic              settle_timeout_o
);

   generate
      if (CLK_PER_US < 1)                    begin : g_bad_clk  $error("CLK_PER_US must be >= 1"); end
      if (TMO_W < 1 || TMO_W > 32)           begin : g_bad_tmo  $error("TMO_W out of range");      end
      if (DATA_W < 1)                        begin : g_bad_data $error("DATA_W must be >= 1");     end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync $error("SYNC_STAGES out of range"); end
   endgenerate

   logic ptr_busy_s, ptr_clk_s, xflag_s;

   ppx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ptr_busy_i, ptr_clk_i, xflag_i}),
      .q_o   ({ptr_busy_s, ptr_clk_s, xflag_s})
   );

   logic use_xf_c;

   ppx_xflag_rule u_rule (
      .phase_i  (phase_i),
      .family_i (family_i),
      .ignore_i (xflag_ignore_i),
      .use_o    (use_xf_c)
   );

   seq_state_e st_q;
   logic       xf_snap_q;
   logic       use_xf_q;
   logic       waiting;
   logic       expired;

   assign waiting = (st_q == ST_W_ACK) || (st_q == ST_W_SET);

   ppx_timer #(.CLK_PER_US(CLK_PER_US), .TMO_W(TMO_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (!waiting),
      .limit_i   (timeout_us_i),
      .expired_o (expired)
   );

   logic ack_ok;
   logic settle_ok;

   always_comb begin
      ack_ok    = !ptr_clk_s && (!use_xf_q || (xflag_s != xf_snap_q));
      settle_ok = ptr_busy_s && ptr_clk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q             <= ST_IDLE;
         xf_snap_q        <= 1'b0;
         use_xf_q         <= 1'b0;
         drive_o          <= 1'b0;
         select_in_o      <= 1'b0;
         host_busy_o      <= 1'b1;
         strobe_n_o       <= 1'b1;
         data_o           <= '0;
         done_o           <= 1'b0;
         phase_o          <= PH_TERM;
         connected_o      <= 1'b0;
         ack_timeout_o    <= 1'b0;
         settle_timeout_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (phase_i == PH_TERM) begin
                     done_o <= 1'b1;
                  end else begin
                     st_q             <= ST_ASSERT;
                     xf_snap_q        <= xflag_s;
                     use_xf_q         <= use_xf_c;
                     phase_o          <= phase_i;
                     connected_o      <= 1'b1;
                     drive_o          <= 1'b1;
                     select_in_o      <= 1'b0;
                     host_busy_o      <= 1'b1;
                     strobe_n_o       <= 1'b1;
                     data_o           <= '0;
                     ack_timeout_o    <= 1'b0;
                     settle_timeout_o <= 1'b0;
                  end
               end
            end
            ST_ASSERT: st_q <= ST_W_ACK;
            ST_W_ACK: begin
               if (ack_ok) begin
                  st_q        <= ST_DROP;
                  host_busy_o <= 1'b0;
               end else if (expired) begin
                  st_q          <= ST_FINAL;
                  ack_timeout_o <= 1'b1;
               end
            end
            ST_DROP: st_q <= ST_W_SET;
            ST_W_SET: begin
               if (settle_ok) begin
                  st_q <= ST_FINAL;
               end else if (expired) begin
                  st_q             <= ST_FINAL;
                  settle_timeout_o <= 1'b1;
               end
            end
            ST_FINAL: begin
               st_q        <= ST_IDLE;
               host_busy_o <= 1'b1;
               phase_o     <= PH_TERM;
               connected_o <= 1'b0;
               drive_o     <= 1'b0;
               done_o      <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ppx_exit_chk.sv
module ppx_exit_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [2:0]        phase_i,
   input logic              drive_o,
   input logic              select_in_o,
   input logic              host_busy_o,
   input logic              strobe_n_o,
   input logic [DATA_W-1:0] data_o,
   input logic              done_o,
   input logic [2:0]        phase_o,
   input logic              connected_o,
   input logic              ack_timeout_o,
   input logic              settle_timeout_o,
   input logic              ptr_busy_s,
   input logic              ptr_clk_s
);

   assert_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !drive_o && phase_i == 3'd6) |=> (done_o && !drive_o && host_busy_o));

   assert_host_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drive_o |-> (!select_in_o && strobe_n_o && data_o == '0));

   assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_busy_o) |-> (drive_o && !$past(ptr_clk_s)));

   assert_ack_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_timeout_o) |-> (host_busy_o ##1 done_o));

   assert_settle_met_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(host_busy_o) && !settle_timeout_o) |-> $past(ptr_busy_s && ptr_clk_s, 2));

   assert_complete_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (phase_o == 3'd6 && !connected_o && !drive_o && host_busy_o));

endmodule

bind ppmode_exit ppx_exit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .start_i          (start_i),
   .phase_i          (phase_i),
   .drive_o          (drive_o),
   .select_in_o      (select_in_o),
   .host_busy_o      (host_busy_o),
   .strobe_n_o       (strobe_n_o),
   .data_o           (data_o),
   .done_o           (done_o),
   .phase_o          (phase_o),
   .connected_o      (connected_o),
   .ack_timeout_o    (ack_timeout_o),
   .settle_timeout_o (settle_timeout_o),
   .ptr_busy_s       (ptr_busy_s),
   .ptr_clk_s        (ptr_clk_s)
);

// File: tb/ppmode_exit_test.sv
module ppmode_exit_test;

   localparam int P  = 4;
   localparam int S  = 2;
   localparam int TW = 8;
   localparam int DW = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    phase_i = 3'd0;
   logic [1:0]    family_i = 2'd0;
   logic          ign_i = 1'b0;
   logic [TW-1:0] tmo_i = 8'd5;
   logic          ptr_busy_i = 1'b1;
   logic          ptr_clk_i = 1'b1;
   logic          xflag_i = 1'b0;

   logic          drive_o, select_in_o, host_busy_o, strobe_n_o, done_o;
   logic [DW-1:0] data_o;
   logic [2:0]    phase_o;
   logic          connected_o, ack_timeout_o, settle_timeout_o;

   ppmode_exit #(.CLK_PER_US(P), .TMO_W(TW), .DATA_W(DW), .SYNC_STAGES(S)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
      .family_i(family_i), .xflag_ignore_i(ign_i), .timeout_us_i(tmo_i),
      .ptr_busy_i(ptr_busy_i), .ptr_clk_i(ptr_clk_i), .xflag_i(xflag_i),
      .drive_o(drive_o), .select_in_o(select_in_o), .host_busy_o(host_busy_o),
      .strobe_n_o(strobe_n_o), .data_o(data_o), .done_o(done_o),
      .phase_o(phase_o), .connected_o(connected_o),
      .ack_timeout_o(ack_timeout_o), .settle_timeout_o(settle_timeout_o)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int ms, k, m_phase;
   bit m_drive, m_hb, m_done, m_conn, m_ack, m_set, m_snap, m_use;
   bit qb[S], qc[S], qx[S];

   function automatic bit xf_policy(int ph, int fam, bit ign);
      bit rev = (ph == 2) || (ph == 3);
      if (ign) return 1'b0;
      return (fam <= 1) ? rev : !rev;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; k = 0; m_phase = 6;
         m_drive = 0; m_hb = 1; m_done = 0; m_conn = 0; m_ack = 0; m_set = 0;
         m_snap = 0; m_use = 0;
         for (int i = 0; i < S; i++) begin qb[i] = 0; qc[i] = 0; qx[i] = 0; end
      end else begin
         bit sb, sc, sx;
         sb = qb[S-1]; sc = qc[S-1]; sx = qx[S-1];
         m_done = 0;
         case (ms)
            0: if (start_i) begin
                  if (phase_i == 3'd6) m_done = 1;
                  else begin
                     m_snap = sx; m_use = xf_policy(phase_i, family_i, ign_i);
                     m_phase = phase_i; m_conn = 1; m_drive = 1; m_hb = 1;
                     m_ack = 0; m_set = 0; ms = 1;
                  end
               end
            1: begin ms = 2; k = 0; end
            2: if (!sc && (!m_use || sx != m_snap)) begin ms = 3; m_hb = 0; end
               else if (k / P >= int'(tmo_i)) begin ms = 5; m_ack = 1; end
               else k++;
            3: begin ms = 4; k = 0; end
            4: if (sb && sc) ms = 5;
               else if (k / P >= int'(tmo_i)) begin ms = 5; m_set = 1; end
               else k++;
            default: begin
               m_hb = 1; m_phase = 6; m_conn = 0; m_done = 1; m_drive = 0; ms = 0;
            end
         endcase
         for (int i = S - 1; i > 0; i--) begin
            qb[i] = qb[i-1]; qc[i] = qc[i-1]; qx[i] = qx[i-1];
         end
         qb[0] = ptr_busy_i; qc[0] = ptr_clk_i; qx[0] = xflag_i;
      end
   end

   // per-cycle comparison, covers R3 R4 R6 R9 R11 timing
   bit saw_hb_low = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         int act, exp;
         act = {drive_o, host_busy_o, done_o, connected_o, ack_timeout_o,
                settle_timeout_o, phase_o, select_in_o, strobe_n_o, data_o};
         exp = {m_drive, m_hb, m_done, m_conn, m_ack, m_set, 3'(m_phase),
                1'b0, 1'b1, 8'h00};
         chk(act == exp, "R4 model-compare", act, exp);
         if (!host_busy_o) saw_hb_low = 1;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic launch(input int ph, input int fam, input bit ign);
      @(negedge clk);
      phase_i = 3'(ph); family_i = 2'(fam); ign_i = ign; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!done_o && n < 500) begin @(negedge clk); n++; end
   endtask

   task automatic settle_lines(input bit xf);
      ptr_busy_i = 1'b1; ptr_clk_i = 1'b1; xflag_i = xf;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset values while reset held
      chk({drive_o, select_in_o, host_busy_o, strobe_n_o, done_o, connected_o,
           ack_timeout_o, settle_timeout_o} == 8'b0011_0000, "R1 reset lines",
          {drive_o, select_in_o, host_busy_o, strobe_n_o, done_o, connected_o,
           ack_timeout_o, settle_timeout_o}, 8'b0011_0000);
      chk(phase_o == 3'd6 && data_o == 0, "R1 reset phase", phase_o, 6);
      rst_n = 1'b1;
      settle_lines(1'b1);

      // R2 skip when already terminated
      launch(6, 0, 0);
      chk(done_o && !drive_o && host_busy_o, "R2 skip done", {done_o, drive_o, host_busy_o}, 3'b101);
      @(negedge clk);
      chk(!done_o && !drive_o, "R2 no handshake", {done_o, drive_o}, 0);

      // nibble reverse idle, xflag in use (R5 R6 R3 R4 R9 R11)
      settle_lines(1'b1);
      saw_hb_low = 0;
      launch(2, 0, 0);
      chk(drive_o && !select_in_o && host_busy_o && strobe_n_o && data_o == 0,
          "R3 event lines", {drive_o, select_in_o, host_busy_o, strobe_n_o}, 4'b1011);
      chk(phase_o == 3'd2 && connected_o, "R3 phase captured", phase_o, 2);
      ptr_clk_i = 1'b0;
      repeat (7) @(negedge clk);
      chk(host_busy_o, "R6 xflag unchanged holds", host_busy_o, 1);
      xflag_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(host_busy_o, "R4 sync latency", host_busy_o, 1);
      repeat (2) @(negedge clk);
      chk(!host_busy_o, "R6 inverted xflag releases", host_busy_o, 0);
      ptr_busy_i = 1'b1; ptr_clk_i = 1'b1;
      wait_done(n);
      chk(done_o && !ack_timeout_o && !settle_timeout_o, "R9 settle met",
          {done_o, ack_timeout_o, settle_timeout_o}, 3'b100);
      chk(phase_o == 3'd6 && !connected_o && !drive_o && host_busy_o, "R11 completion",
          {phase_o, connected_o, drive_o, host_busy_o}, {3'd6, 3'b001});
      @(negedge clk);
      chk(!done_o, "R11 single pulse", done_o, 0);

      // R7 ignore: xflag left as sampled
      settle_lines(1'b1);
      launch(2, 0, 1);
      ptr_clk_i = 1'b0;
      repeat (5) @(negedge clk);
      chk(!host_busy_o, "R7 xflag ignored", host_busy_o, 0);
      ptr_clk_i = 1'b1;
      wait_done(n);
      chk(done_o && !settle_timeout_o, "R7 completes", settle_timeout_o, 0);

      // R5 ECP family, forward phase: xflag in use
      settle_lines(1'b0);
      launch(4, 2, 0);
      ptr_clk_i = 1'b0;
      repeat (6) @(negedge clk);
      chk(host_busy_o, "R5 ECP forward waits on xflag", host_busy_o, 1);
      xflag_i = 1'b1;
      repeat (4) @(negedge clk);
      chk(!host_busy_o, "R5 ECP forward xflag released", host_busy_o, 0);
      ptr_clk_i = 1'b1;
      wait_done(n);

      // R5 byte family, forward phase: xflag not in use
      settle_lines(1'b0);
      launch(4, 1, 0);
      ptr_clk_i = 1'b0;
      repeat (5) @(negedge clk);
      chk(!host_busy_o, "R5 byte forward ignores xflag", host_busy_o, 0);
      ptr_clk_i = 1'b1;
      wait_done(n);

      // R8 R12 first wait expires
      settle_lines(1'b0);
      tmo_i = 8'd3;
      saw_hb_low = 0;
      @(negedge clk);
      phase_i = 3'd3; family_i = 2'd0; ign_i = 1'b1; start_i = 1'b1;
      n = 0;
      @(negedge clk); n++;
      start_i = 1'b0;
      while (!done_o && n < 500) begin @(negedge clk); n++; end
      chk(n == 4 + 3 * P, "R12 timeout duration", n, 4 + 3 * P);
      chk(ack_timeout_o && !saw_hb_low, "R8 ack timeout no busy drop", {ack_timeout_o, saw_hb_low}, 2'b10);
      chk(phase_o == 3'd6 && !connected_o, "R8 still terminates", phase_o, 6);

      // R10 settle wait expires
      settle_lines(1'b0);
      saw_hb_low = 0;
      launch(3, 0, 1);
      ptr_clk_i = 1'b0; ptr_busy_i = 1'b0;
      wait_done(n);
      chk(settle_timeout_o && !ack_timeout_o && saw_hb_low, "R10 settle timeout noted",
          {settle_timeout_o, ack_timeout_o, saw_hb_low}, 3'b101);
      chk(done_o && phase_o == 3'd6, "R10 completes", phase_o, 6);

      // R13 condition and expiry on the same edge
      settle_lines(1'b0);
      saw_hb_low = 0;
      @(negedge clk);
      phase_i = 3'd2; family_i = 2'd0; ign_i = 1'b1; start_i = 1'b1;
      n = 0;
      @(negedge clk); n++;
      start_i = 1'b0;
      while (n < 3 * P) begin @(negedge clk); n++; end
      ptr_clk_i = 1'b0;
      repeat (4) @(negedge clk);
      chk(saw_hb_low && !ack_timeout_o, "R13 handshake wins tie",
          {saw_hb_low, ack_timeout_o}, 2'b10);
      ptr_clk_i = 1'b1;
      wait_done(n);
      chk(done_o && !ack_timeout_o, "R13 completes cleanly", ack_timeout_o, 0);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule